// File: doc/BRIEF.md
# Transport Clock Reference Stamper and Interval Monitor

This block sits in the downlink transport stream, one byte per cycle, with one register stage between input and output. It keeps its own copy of the 27 MHz network clock. The copy is a 33-bit base that advances at 90 kHz and a 9-bit extension that counts 0 to 299 at the core clock. A serial command input can reload the copy from a master reference. Packets that carry the clock reference have a configured packet identifier, an adaptation field and the reference flag. When such a packet passes, its six reference bytes are rewritten with the current local value.

The block also times the gap between reference packets that leave it. If the gap grows past a configured threshold, it sets a sticky error flag that a host pulse clears, and it advances a saturating event count. It then builds a reference packet of its own. This packet takes the place of the next upstream packet whose first byte arrives after the timeout.

Top module: `ncr_inserter`

## Requirements
- R1: Every byte accepted while `in_valid` is high appears on `out_data` one cycle later, with `out_valid` and `out_sop` following `in_valid` and `in_valid && in_sop` with the same one-cycle delay.
- R2: After reset the local clock is zero. On each clock edge the 9-bit extension counts up. An edge that finds it at 299 sets it to 0 and increments the 33-bit base.
- R3: A packet is a reference packet when all of these hold: its PID matches `cfg_pid` (low 5 bits of byte 1, then byte 2); bit 5 of byte 3 is set; byte 4 is at least 7; bit 4 of byte 5 is set. Its bytes 6 to 11 leave as the 48-bit value {base, 6'b111111, ext}, most significant byte first. The value is the clock held just before the edge that accepts byte 6. All other bytes are unchanged.
- R4: A packet that misses any one condition of R3 (other PID, bit 5 of byte 3 clear, byte 4 below 7, or bit 4 of byte 5 clear) passes byte for byte unchanged.
- R5: While `ser_en` stays high for 42 consecutive edges, `ser_dat` is shifted in MSB first: 33 base bits, then 9 extension bits. On the edge of the 42nd bit the clock takes that value, and it resumes counting on the next edge. Dropping `ser_en` before the 42nd bit discards the partial word.
- R6: The interval timer restarts on the edge that accepts byte 11 of any outgoing reference packet, whether stamped or generated. A timeout event occurs on the (`cfg_thr`+1)-th later edge if no reference byte 11 leaves first. `cfg_thr` must be below all ones.
- R7: `err_flag` is set by a timeout event and stays set until an `err_clr` pulse. An event on the same edge as the pulse wins.
- R8: `tmo_count` increments on each timeout event and holds at its all-ones value.
- R9: After an event, the first packet whose first byte is accepted on a later edge is replaced entirely. The replacement bytes are: 0x47; {3'b000, pid[12:8]}; pid[7:0]; 0x20; 183; 0x10; bytes 6 to 11 stamped as in R3; 0xFF for all remaining bytes.
- R10: A single gap without reference packets produces exactly one timeout event, however long it lasts.
- R11: During and after reset, `out_valid`, `err_flag` and `tmo_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, 27 MHz clock-reference rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial reload frame enable |
| ser_dat | input | 1 | Serial reload data, MSB first |
| cfg_pid | input | 13 | PID of reference packets |
| cfg_thr | input | TMR_W | Interval threshold in cycles |
| err_clr | input | 1 | Host pulse clearing the error flag |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is first of a packet |
| in_data | input | 8 | Input stream byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is first of a packet |
| out_data | output | 8 | Output stream byte |
| err_flag | output | 1 | Sticky interval error |
| tmo_count | output | CNT_W | Saturating count of timeout events |

## Verification
The stamping path is driven with true reference packets and with four lookalikes, each of which fails exactly one detection condition. A wrong match on any single field therefore shows up as a changed or an unchanged byte. Field values are decoded and compared with a count of edges since reset or since a serial reload, covering the extension wrap, a full reload and an aborted one. Random mixes of all packet kinds, with gaps inside and between packets, are compared cycle by cycle with a bench model. This exposes replacement aimed at the wrong packet and timer restarts from the wrong byte. Directed idle runs pin down the exact timeout edge, the single event per gap and count saturation.

// File: rtl/ncr_ins_pkg.sv
package ncr_ins_pkg;

    localparam int PID_W      = 13;
    localparam int EXT_TOP    = 299;
    localparam int FLD_FIRST  = 6;
    localparam int FLD_LAST   = 11;

    localparam logic [7:0] SYNC_BYTE  = 8'h47;
    localparam logic [7:0] GEN_CTRL   = 8'h20;
    localparam logic [7:0] GEN_AFLEN  = 8'd183;
    localparam logic [7:0] GEN_FLAGS  = 8'h10;
    localparam logic [7:0] STUFF_BYTE = 8'hFF;
    localparam logic [7:0] AF_MIN_LEN = 8'd7;

    typedef struct packed {
        logic [32:0] base;
        logic [8:0]  ext;
    } ncr_t;

    localparam int NCR_BITS = $bits(ncr_t);

    typedef logic [47:0] clk_fld_t;

    typedef struct packed {
        logic       valid;
        logic       sop;
        logic [7:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        SEL_PASS,
        SEL_STAMP,
        SEL_GEN
    } byte_sel_t;

    function automatic ncr_t ncr_next(ncr_t v);
        ncr_t r;
        r = v;
        if (v.ext >= 9'(EXT_TOP)) begin
            r.ext  = '0;
            r.base = v.base + 33'd1;
        end else begin
            r.ext = v.ext + 9'd1;
        end
        return r;
    endfunction

    function automatic clk_fld_t fld_pack(ncr_t v);
        return {v.base, 6'b111111, v.ext};
    endfunction

    function automatic logic [7:0] fld_byte(clk_fld_t f, logic [7:0] idx);
        logic [2:0] k;
        clk_fld_t   s;
        k = 3'(8'(FLD_LAST) - idx);
        s = f >> (8 * k);
        return s[7:0];
    endfunction

    function automatic logic [7:0] gen_byte(logic [7:0] idx, logic [PID_W-1:0] pid, clk_fld_t f);
        logic [7:0] b;
        if (idx == 8'd0)                                  b = SYNC_BYTE;
        else if (idx == 8'd1)                             b = {3'b000, pid[12:8]};
        else if (idx == 8'd2)                             b = pid[7:0];
        else if (idx == 8'd3)                             b = GEN_CTRL;
        else if (idx == 8'd4)                             b = GEN_AFLEN;
        else if (idx == 8'd5)                             b = GEN_FLAGS;
        else if (idx <= 8'(FLD_LAST))                     b = fld_byte(f, idx);
        else                                              b = STUFF_BYTE;
        return b;
    endfunction

endpackage

// File: rtl/ncr_clock.sv
module ncr_clock
    import ncr_ins_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser_en,
    input  logic ser_dat,
    output ncr_t now_o
);
    localparam int CW = $clog2(NCR_BITS + 1);

    logic [NCR_BITS-1:0] sh_q;
    logic [CW-1:0]       bc_q;
    logic                load;
    ncr_t                load_val;

    assign load     = ser_en && (bc_q == CW'(NCR_BITS - 1));
    assign load_val = ncr_t'({sh_q[NCR_BITS-2:0], ser_dat});

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            bc_q  <= '0;
            now_o <= '0;
        end else begin
            if (ser_en) begin
                sh_q <= {sh_q[NCR_BITS-2:0], ser_dat};
                bc_q <= load ? '0 : bc_q + CW'(1);
            end else begin
                bc_q <= '0;
            end
            now_o <= load ? load_val : ncr_next(now_o);
        end
    end

    // R2
    ext_range_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> (now_o.ext <= 9'(EXT_TOP)));

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        bc_q <= CW'(NCR_BITS - 1));

endmodule

// File: rtl/interval_mon.sv
module interval_mon
    import ncr_ins_pkg::*;
#(
    parameter int TMR_W = 20,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_W-1:0] thr,
    input  logic             ref_leave,
    input  logic             gen_start,
    input  logic             err_clr,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o
);
    localparam logic [TMR_W-1:0] TMR_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TMR_W-1:0] tmr_q;
    logic             evt;

    assign evt = !ref_leave && (tmr_q == thr) && (tmr_q != TMR_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q  <= '0;
            err_o  <= 1'b0;
            cnt_o  <= '0;
            pend_o <= 1'b0;
        end else begin
            if (ref_leave)             tmr_q <= '0;
            else if (tmr_q != TMR_MAX) tmr_q <= tmr_q + TMR_W'(1);
            err_o  <= evt || (err_o && !err_clr);
            if (evt && cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
            pend_o <= evt || (pend_o && !gen_start);
        end
    end

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> err_o);

    // R8
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_o >= $past(cnt_o));

    // R10
    one_evt_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !gen_start) |=> pend_o);

endmodule

// File: rtl/pkt_stamper.sv
module pkt_stamper
    import ncr_ins_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [PID_W-1:0] cfg_pid,
    input  ncr_t             ncr_now,
    input  logic             gen_pending,
    output beat_t            out_o,
    output logic             gen_start,
    output logic             ref_leave
);
    logic [7:0]       idx_q;
    logic [PID_W-1:0] pid_q;
    logic             af_q, len_q, pcrf_q, gen_q;
    clk_fld_t         snap_q;

    logic [7:0]  cur_idx;
    logic        gen_now, hit, in_fld;
    clk_fld_t    fld;
    byte_sel_t   sel;
    logic [7:0]  nxt_byte;

    assign cur_idx = in_sop ? 8'd0 : ((idx_q == 8'hFF) ? 8'hFF : idx_q + 8'd1);
    assign gen_now = in_sop ? gen_pending : gen_q;
    assign hit     = !in_sop && (pid_q == cfg_pid) && af_q && len_q && pcrf_q;
    assign in_fld  = (cur_idx >= 8'(FLD_FIRST)) && (cur_idx <= 8'(FLD_LAST));
    assign fld     = (cur_idx == 8'(FLD_FIRST)) ? fld_pack(ncr_now) : snap_q;

    always_comb begin
        if (gen_now)              sel = SEL_GEN;
        else if (hit && in_fld)   sel = SEL_STAMP;
        else                      sel = SEL_PASS;
        case (sel)
            SEL_GEN:   nxt_byte = gen_byte(cur_idx, cfg_pid, fld);
            SEL_STAMP: nxt_byte = fld_byte(fld, cur_idx);
            default:   nxt_byte = in_data;
        endcase
    end

    assign ref_leave = in_valid && (cur_idx == 8'(FLD_LAST)) && (gen_now || hit);
    assign gen_start = in_valid && in_sop && gen_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o  <= '0;
            idx_q  <= '0;
            pid_q  <= '0;
            af_q   <= 1'b0;
            len_q  <= 1'b0;
            pcrf_q <= 1'b0;
            gen_q  <= 1'b0;
            snap_q <= '0;
        end else begin
            out_o.valid <= in_valid;
            out_o.sop   <= in_valid && in_sop;
            out_o.data  <= nxt_byte;
            if (in_valid) begin
                idx_q <= cur_idx;
                if (in_sop) begin
                    gen_q  <= gen_pending;
                    af_q   <= 1'b0;
                    len_q  <= 1'b0;
                    pcrf_q <= 1'b0;
                end
                case (cur_idx)
                    8'd1:    pid_q[12:8] <= in_data[4:0];
                    8'd2:    pid_q[7:0]  <= in_data;
                    8'd3:    af_q        <= in_data[5];
                    8'd4:    len_q       <= (in_data >= AF_MIN_LEN);
                    8'd5:    pcrf_q      <= in_data[4];
                    default: ;
                endcase
                if (cur_idx == 8'(FLD_FIRST)) snap_q <= fld;
            end
        end
    end

    // R9
    gen_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        gen_start |=> (out_o.sop && out_o.valid && out_o.data == SYNC_BYTE));

    // R1
    hdr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !gen_now && cur_idx < 8'(FLD_FIRST)) |=> (out_o.data == $past(in_data)));

endmodule

// File: rtl/ncr_inserter.sv
module ncr_inserter
    import ncr_ins_pkg::*;
#(
    parameter int TMR_W = 20,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_en,
    input  logic             ser_dat,
    input  logic [12:0]      cfg_pid,
    input  logic [TMR_W-1:0] cfg_thr,
    input  logic             err_clr,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_data,
    output logic             err_flag,
    output logic [CNT_W-1:0] tmo_count
);
    ncr_t  ncr_now;
    beat_t out_b;
    logic  gen_start, ref_leave, pend;

    ncr_clock u_clock (
        .clk     (clk),
        .rst     (rst),
        .ser_en  (ser_en),
        .ser_dat (ser_dat),
        .now_o   (ncr_now)
    );

    pkt_stamper u_stamp (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_data     (in_data),
        .cfg_pid     (cfg_pid),
        .ncr_now     (ncr_now),
        .gen_pending (pend),
        .out_o       (out_b),
        .gen_start   (gen_start),
        .ref_leave   (ref_leave)
    );

    interval_mon #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .thr       (cfg_thr),
        .ref_leave (ref_leave),
        .gen_start (gen_start),
        .err_clr   (err_clr),
        .err_o     (err_flag),
        .cnt_o     (tmo_count),
        .pend_o    (pend)
    );

    assign out_valid = out_b.valid;
    assign out_sop   = out_b.sop;
    assign out_data  = out_b.data;

    // R11
    rst_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !err_flag && tmo_count == '0));

endmodule

// File: tb/ncr_inserter_tb_top.sv
`timescale 1ns/1ps
module ncr_inserter_tb_top;
    localparam int TW = 16;
    localparam int CW = 4;
    localparam logic [12:0] PID = 13'h0A5;

    logic clk = 1'b0, rst = 1'b1, ser_en = 1'b0, ser_dat = 1'b0, err_clr = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [12:0] cfg_pid = PID;
    logic [TW-1:0] cfg_thr = 16'hFFF0;
    logic out_valid, out_sop, err_flag;
    logic [7:0] out_data;
    logic [CW-1:0] tmo_count;

    always #2.5 clk = ~clk;

    ncr_inserter #(.TMR_W(TW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_dat(ser_dat),
        .cfg_pid(cfg_pid), .cfg_thr(cfg_thr), .err_clr(err_clr),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
        .err_flag(err_flag), .tmo_count(tmo_count));

    int checks = 0, fails = 0, edges = 0, rel_edge = 0, e6 = 0, e11 = 0;
    bit done = 1'b0;
    logic [7:0] pkt [0:187];
    logic [7:0] obs [0:255];
    int obs_n = 0;

    // bench model state
    logic [32:0] m_base; logic [8:0] m_ext; logic [41:0] m_sh; int m_bc;
    int m_tmr, m_cnt, m_idx; bit m_pend, m_err, m_gen, m_af, m_len, m_pf;
    logic [47:0] m_snap; logic [12:0] m_pid;
    bit e_v, e_sop; logic [7:0] e_d; string e_tag;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_base = '0; m_ext = '0; m_sh = '0; m_bc = 0; m_tmr = 0; m_cnt = 0; m_idx = 0;
        m_pend = 0; m_err = 0; m_gen = 0; m_af = 0; m_len = 0; m_pf = 0;
        m_snap = '0; m_pid = '0; e_v = 0; e_sop = 0; e_d = 0; e_tag = "R11";
    endtask

    function automatic logic [7:0] tb_gen(int i, logic [47:0] f);
        case (i)
            0: return 8'h47;
            1: return {3'b000, cfg_pid[12:8]};
            2: return cfg_pid[7:0];
            3: return 8'h20;
            4: return 8'd183;
            5: return 8'h10;
            default: return (i <= 11) ? f[8*(11-i) +: 8] : 8'hFF;
        endcase
    endfunction

    task automatic model_edge(bit v, bit s, logic [7:0] d, bit se, bit sd, bit clr);
        int ci; bit gnow, hit, rl, evt, gst, ld;
        logic [47:0] cur_f, f; logic [41:0] nv;
        cur_f = {m_base, 6'h3F, m_ext};
        rl = 0;
        e_v = v; e_sop = v && s;
        gst = v && s && m_pend;
        if (v) begin
            ci   = s ? 0 : ((m_idx >= 255) ? 255 : m_idx + 1);
            gnow = s ? m_pend : m_gen;
            hit  = !s && (m_pid == cfg_pid) && m_af && m_len && m_pf;
            f    = (ci == 6) ? cur_f : m_snap;
            if (gnow) begin e_d = tb_gen(ci, f); e_tag = "R9"; end
            else if (hit && ci >= 6 && ci <= 11) begin e_d = f[8*(11-ci) +: 8]; e_tag = "R3"; end
            else begin e_d = d; e_tag = "R4"; end
            rl = (ci == 11) && (gnow || hit);
            m_idx = ci;
            if (s) begin m_gen = m_pend; m_af = 0; m_len = 0; m_pf = 0; end
            case (ci)
                1: m_pid[12:8] = d[4:0];
                2: m_pid[7:0] = d;
                3: m_af = d[5];
                4: m_len = (d >= 8'd7);
                5: m_pf = d[4];
                default: ;
            endcase
            if (ci == 6) m_snap = cur_f;
        end
        evt = !rl && (m_tmr == int'(cfg_thr)) && (m_tmr != 65535);
        m_tmr = rl ? 0 : ((m_tmr == 65535) ? 65535 : m_tmr + 1);
        m_err = evt || (m_err && !clr);
        if (evt && m_cnt < 15) m_cnt++;
        m_pend = evt || (m_pend && !gst);
        ld = se && (m_bc == 41);
        nv = {m_sh[40:0], sd};
        if (se) begin m_sh = nv; m_bc = ld ? 0 : m_bc + 1; end else m_bc = 0;
        if (ld) {m_base, m_ext} = nv;
        else if (m_ext >= 9'd299) begin m_ext = 0; m_base = m_base + 33'd1; end
        else m_ext = m_ext + 9'd1;
    endtask

    task automatic step(bit v, bit s, logic [7:0] d, bit se, bit sd, bit clr);
        in_valid = v; in_sop = s; in_data = d; ser_en = se; ser_dat = sd; err_clr = clr;
        @(posedge clk);
        edges++;
        if (rst) model_reset(); else model_edge(v, s, d, se, sd, clr);
        @(negedge clk);
        check(out_valid == e_v, "R1", "out_valid", out_valid, e_v);
        if (e_v) begin
            check(out_sop == e_sop, "R1", "out_sop", out_sop, e_sop);
            check(out_data == e_d, e_tag, "out_data", out_data, e_d);
            if (out_sop) obs_n = 0;
            obs[obs_n] = out_data;
            if (obs_n < 255) obs_n++;
        end
        check(err_flag == m_err, "R7", "err_flag", err_flag, m_err);
        check(int'(tmo_count) == m_cnt, "R8", "tmo_count", tmo_count, m_cnt);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0, 0);
    endtask

    // kinds: 0 ref, 1 other PID, 2 no adaptation bit, 3 short length, 4 no flag, 5 plain data
    task automatic build(int kind);
        logic [12:0] p;
        p = (kind == 1) ? (PID ^ 13'h001) : ((kind == 5) ? 13'h100 : PID);
        pkt[0] = 8'h47;
        pkt[1] = {3'b010, p[12:8]};
        pkt[2] = p[7:0];
        pkt[3] = (kind == 2 || kind == 5) ? 8'h10 : 8'h30;
        pkt[4] = (kind == 3) ? 8'd5 : 8'd7;
        pkt[5] = (kind == 4) ? 8'h00 : 8'h10;
        for (int i = 6; i < 188; i++) pkt[i] = 8'($urandom);
    endtask

    task automatic send(int gap_mod);
        for (int i = 0; i < 188; i++) begin
            if (gap_mod != 0 && ($urandom % gap_mod) == 0) idle(1);
            step(1, i == 0, pkt[i], 0, 0, 0);
            if (i == 6) e6 = edges;
            if (i == 11) e11 = edges;
        end
    endtask

    function automatic logic [47:0] obs_fld();
        return {obs[6], obs[7], obs[8], obs[9], obs[10], obs[11]};
    endfunction

    function automatic logic [41:0] add_ticks(logic [32:0] b, logic [8:0] x, int n);
        int t;
        t = int'(x) + n;
        return {b + 33'(t / 300), 9'(t % 300)};
    endfunction

    task automatic ser_load(logic [41:0] v, int nbits);
        for (int i = 0; i < nbits; i++) step(0, 0, 8'h00, 1, v[41-i], 0);
    endtask

    initial begin
        int unsigned seed;
        logic [47:0] f;
        logic [41:0] exp_v, ld_v;
        int ld_edge, c0, ev_edge;
        seed = $urandom(32'd4242);
        // reset, R11
        for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 0, 0, 0);
        rel_edge = edges;
        rst = 1'b0;
        check(!out_valid, "R11", "out_valid after reset", out_valid, 0);
        check(!err_flag, "R11", "err_flag after reset", err_flag, 0);
        check(tmo_count == 0, "R11", "tmo_count after reset", tmo_count, 0);

        // R2: free count and extension wrap, read through a stamped packet
        idle(350);
        build(0); send(0);
        f = obs_fld();
        exp_v = add_ticks(33'd0, 9'd0, e6 - rel_edge - 1);
        check({f[47:15], f[8:0]} == exp_v, "R2", "stamped clock after reset", {f[47:15], f[8:0]}, exp_v);
        check(f[14:9] == 6'h3F, "R3", "reserved bits", f[14:9], 6'h3F);
        check(obs[4] == pkt[4] && obs[12] == pkt[12], "R3", "non-field bytes kept", obs[12], pkt[12]);

        // R4: each lookalike passes unchanged
        for (int k = 1; k <= 4; k++) begin
            build(k); send(0);
            check(obs_fld() == {pkt[6], pkt[7], pkt[8], pkt[9], pkt[10], pkt[11]}, "R4",
                  $sformatf("lookalike kind %0d", k), obs_fld(),
                  {pkt[6], pkt[7], pkt[8], pkt[9], pkt[10], pkt[11]});
        end

        // R5: full reload, then aborted partial frame
        ld_v = {33'h1_2345_6789, 9'd297};
        ser_load(ld_v, 42);
        ld_edge = edges;
        build(0); send(0);
        f = obs_fld();
        exp_v = add_ticks(ld_v[41:9], ld_v[8:0], e6 - ld_edge - 1);
        check({f[47:15], f[8:0]} == exp_v, "R5", "clock after reload", {f[47:15], f[8:0]}, exp_v);
        ser_load(42'h3FF_FFFF_FFFF, 20);
        idle(3);
        build(0); send(0);
        f = obs_fld();
        exp_v = add_ticks(ld_v[41:9], ld_v[8:0], e6 - ld_edge - 1);
        check({f[47:15], f[8:0]} == exp_v, "R5", "aborted frame ignored", {f[47:15], f[8:0]}, exp_v);

        // R6 / R7 / R10 / R9 directed
        build(0); send(0);
        cfg_thr = 16'd300;
        step(0, 0, 8'h00, 0, 0, 1);
        c0 = int'(tmo_count);
        ev_edge = 0;
        for (int i = 0; i < 1000 && !err_flag; i++) begin
            step(0, 0, 8'h00, 0, 0, 0);
            if (err_flag) ev_edge = edges;
        end
        check(ev_edge - e11 == 301, "R6", "timeout edge distance", ev_edge - e11, 301);
        idle(600);
        check(int'(tmo_count) == c0 + 1, "R10", "one event per gap", tmo_count, c0 + 1);
        build(5); send(0);
        check(obs[0] == 8'h47 && obs[3] == 8'h20 && obs[4] == 8'd183 && obs[5] == 8'h10,
              "R9", "generated header", {obs[3], obs[4], obs[5]}, 24'h20B710);
        check({obs[1], obs[2]} == {3'b000, PID}, "R9", "generated PID", {obs[1], obs[2]}, {3'b000, PID});
        check(obs[12] == 8'hFF && obs[187] == 8'hFF, "R9", "stuffing", obs[187], 8'hFF);
        check(err_flag, "R7", "error sticky", err_flag, 1);
        step(0, 0, 8'h00, 0, 0, 1);
        check(!err_flag, "R7", "error cleared", err_flag, 0);

        // random mix, model compared every cycle
        cfg_thr = 16'd400;
        for (int n = 0; n < 60; n++) begin
            build(int'($urandom % 6));
            send(8);
            idle(int'($urandom % 20));
        end

        // R8: saturation
        cfg_thr = 16'd40;
        for (int n = 0; n < 20; n++) begin
            idle(45);
            build(5); send(0);
        end
        check(tmo_count == 4'hF, "R8", "count saturates", tmo_count, 4'hF);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule